// File: doc/BRIEF.md
# Flash Memory Controller with Sliced Page Erase

This block controls a small on-chip non-volatile array. The array holds a code area of several pages and a separate user settings area. A CPU drives the block over a simple register port. Through that port it stores words, erases a page, the settings area or everything, and erases a page in short time slices so that no single stall lasts long. Each operation lasts a parameterised number of clock cycles. During that time a stall output holds the CPU and the ready register reads 0.

A sliced erase adds its slice length to a running total kept for the target page. While the total is below the full page-erase time, the page reads as undefined: the data reads as zero and an error flag is raised. When the total reaches the full time, the page becomes all ones, its total returns to zero and its completed-erase counter steps by one.

The settings area accepts only a limited number of stores. After that it must be cleared by a settings erase or by a full erase.

Top module: `flashNvc`

## Requirements
- R1: Out of reset and whenever idle, `stall` is 0 and a read of 0x400 returns 1. An accepted operation raises `stall` for exactly its duration in cycles, and 0x400 reads 0 during that time.
- R2: A bus write that arrives while `stall` is 1 is ignored. It starts no operation and changes no stored state.
- R3: The mode field is bits [1:0] at 0x504 (0 read-only, 1 store, 2 erase, 3 read-only) and reads back there. Store mode is required for a store. A store to code word w (byte address 4*w) takes T_WRITE cycles and leaves old AND new data. Code words read 0xFFFFFFFF after reset.
- R4: The settings area sits at 0x100 + 4*u. It takes at most MAX_UWRITES stores. Any further store is ignored until it is erased.
- R5: The page-erase, full-erase, settings-erase and sliced-erase commands are ignored unless the mode field is 2.
- R6: A write of page index p to 0x508 or to 0x510 sets every word of page p to all ones after T_PAGE cycles. It also clears the page's undefined mark and running total, and leaves other pages unchanged. An index of PAGES or more is ignored.
- R7: Any write to 0x50C sets the whole code area and the whole settings area to all ones after T_ALL cycles. It clears every undefined mark and running total, and resets the settings store count.
- R8: Any write to 0x514 sets the settings area to all ones after T_PAGE cycles. It resets the store count and leaves the code area unchanged.
- R9: 0x51C holds the slice length (0 acts as 1) and reads back. A write of page index p to 0x518 stalls for one slice and adds the slice to the page's total. While the total is below T_PAGE, reads of that page return 0 with `busErr` high.
- R10: When a slice brings the total to T_PAGE or more, the page becomes all ones, is no longer undefined, its total resets to 0, and its counter at 0x600 + 4*p increments by one.
- R11: A sliced erase with page index PAGES or more, including any index meant for the settings area, is ignored and raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Register access valid |
| busWe | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during a read cycle |
| busErr | output | 1 | Read hit an undefined page |
| stall | output | 1 | Operation in progress; CPU held |

## Verification
The hardest state to reach is a page whose running total is non-zero and then gets reset by a full page erase rather than by completion. Only a later series of slices can show that the reset happened. The stimulus issues one slice, erases the page in full, and then issues slices again. A leftover total would complete the erase one slice early, and the bench catches this as a missing error flag. Commands that arrive during a stall are tested by sending a full erase while a page erase is still running, then reading pages it would have cleared.

// File: rtl/flashPkg.sv
package flashPkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 8;
  localparam int TIME_W = 16;

  localparam logic [ADDR_W-1:0] A_READY      = 12'h400;
  localparam logic [ADDR_W-1:0] A_CONFIG     = 12'h504;
  localparam logic [ADDR_W-1:0] A_ERASE_PG   = 12'h508;
  localparam logic [ADDR_W-1:0] A_ERASE_ALL  = 12'h50C;
  localparam logic [ADDR_W-1:0] A_ERASE_ALT  = 12'h510;
  localparam logic [ADDR_W-1:0] A_ERASE_USR  = 12'h514;
  localparam logic [ADDR_W-1:0] A_SLICE_GO   = 12'h518;
  localparam logic [ADDR_W-1:0] A_SLICE_LEN  = 12'h51C;
  localparam logic [ADDR_W-1:0] A_COUNT_BASE = 12'h600;
  localparam logic [ADDR_W-1:0] A_USER_BASE  = 12'h100;

  localparam logic [1:0] MODE_STORE = 2'd1;
  localparam logic [1:0] MODE_ERASE = 2'd2;

  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_UWRITE, OP_PAGE, OP_ALL, OP_UERASE, OP_SLICE
  } opKind_e;

  typedef struct packed {
    logic              fire;
    opKind_e           op;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
    logic [TIME_W-1:0] dur;
  } strobe_t;
endpackage

// File: rtl/flashCtrl.sv
module flashCtrl
  import flashPkg::*;
#(
  parameter int PAGES   = 4,
  parameter int T_WRITE = 3,
  parameter int T_PAGE  = 20,
  parameter int T_ALL   = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              codeHit,
  input  logic              userHit,
  input  logic [IDX_W-1:0]  hitIdx,
  input  logic              uFull,
  output strobe_t           strb,
  output logic              busy,
  output logic [1:0]        cfgMode,
  output logic [TIME_W-1:0] sliceLen
);
  logic              accept;
  logic              pageOk;
  opKind_e           launchOp;
  logic [IDX_W-1:0]  launchIdx;
  logic [TIME_W-1:0] launchDur;
  logic [TIME_W-1:0] timer;
  opKind_e           curOp;
  logic [IDX_W-1:0]  curIdx;
  logic [DATA_W-1:0] curData;
  logic [TIME_W-1:0] curDur;

  assign accept = busValid && busWe && !busy;
  assign pageOk = busWdata < DATA_W'(PAGES);

  always_comb begin
    launchOp  = OP_NONE;
    launchIdx = '0;
    launchDur = '0;
    if (accept) begin
      if (codeHit && cfgMode == MODE_STORE) begin
        launchOp = OP_WRITE; launchIdx = hitIdx; launchDur = TIME_W'(T_WRITE);
      end else if (userHit && cfgMode == MODE_STORE && !uFull) begin
        launchOp = OP_UWRITE; launchIdx = hitIdx; launchDur = TIME_W'(T_WRITE);
      end else if (cfgMode == MODE_ERASE) begin
        if ((busAddr == A_ERASE_PG || busAddr == A_ERASE_ALT) && pageOk) begin
          launchOp = OP_PAGE; launchIdx = IDX_W'(busWdata); launchDur = TIME_W'(T_PAGE);
        end else if (busAddr == A_ERASE_ALL) begin
          launchOp = OP_ALL; launchDur = TIME_W'(T_ALL);
        end else if (busAddr == A_ERASE_USR) begin
          launchOp = OP_UERASE; launchDur = TIME_W'(T_PAGE);
        end else if (busAddr == A_SLICE_GO && pageOk) begin
          launchOp  = OP_SLICE; launchIdx = IDX_W'(busWdata);
          launchDur = (sliceLen == '0) ? TIME_W'(1) : sliceLen;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      timer    <= '0;
      curOp    <= OP_NONE;
      curIdx   <= '0;
      curData  <= '0;
      curDur   <= '0;
      cfgMode  <= '0;
      sliceLen <= '0;
    end else begin
      if (accept && busAddr == A_CONFIG)    cfgMode  <= busWdata[1:0];
      if (accept && busAddr == A_SLICE_LEN) sliceLen <= busWdata[TIME_W-1:0];
      if (launchOp != OP_NONE) begin
        busy    <= 1'b1;
        timer   <= launchDur - TIME_W'(1);
        curOp   <= launchOp;
        curIdx  <= launchIdx;
        curData <= busWdata;
        curDur  <= launchDur;
      end else if (busy) begin
        if (timer == '0) busy <= 1'b0;
        else             timer <= timer - TIME_W'(1);
      end
    end
  end

  always_comb begin
    strb.fire = busy && (timer == '0);
    strb.op   = curOp;
    strb.idx  = curIdx;
    strb.data = curData;
    strb.dur  = curDur;
  end

  p_fire_ends_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> !busy);
  p_hold_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.fire) |=> (busy && $stable(curOp) && $stable(curIdx) && $stable(curData)));
  p_store_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && (curOp == OP_WRITE || curOp == OP_UWRITE)) |-> ($past(cfgMode) == MODE_STORE));
  p_store_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && curOp == OP_UWRITE) |-> !$past(uFull));
  p_erase_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && (curOp == OP_PAGE || curOp == OP_ALL || curOp == OP_UERASE || curOp == OP_SLICE))
      |-> ($past(cfgMode) == MODE_ERASE));
  p_slice_index_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && curOp == OP_SLICE) |-> (curIdx < IDX_W'(PAGES)));
endmodule

// File: rtl/flashData.sv
module flashData
  import flashPkg::*;
#(
  parameter int PAGES       = 4,
  parameter int PAGE_WORDS  = 4,
  parameter int USER_WORDS  = 4,
  parameter int T_PAGE      = 20,
  parameter int MAX_UWRITES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic [1:0]        cfgMode,
  input  logic [TIME_W-1:0] sliceLen,
  input  logic              busValid,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              codeHit,
  output logic              userHit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic              uFull,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr
);
  localparam int CODE_WORDS = PAGES * PAGE_WORDS;
  localparam int CW_IDX = (CODE_WORDS > 1) ? $clog2(CODE_WORDS) : 1;
  localparam int UW_IDX = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1;
  localparam int PG_IDX = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int UC_W   = $clog2(MAX_UWRITES + 1);
  localparam int CNT_W  = 16;
  localparam int ACC_W  = TIME_W + 1;

  logic [DATA_W-1:0] codeMem [CODE_WORDS];
  logic [DATA_W-1:0] userMem [USER_WORDS];
  logic [ACC_W-1:0]  accum   [PAGES];
  logic [CNT_W-1:0]  cycles  [PAGES];
  logic [PAGES-1:0]  undef;
  logic [UC_W-1:0]   uCount;

  logic [ADDR_W-1:0] userOff, cntOff;
  logic              cntHit;
  logic [PG_IDX-1:0] opPage, rdPage;
  logic [ACC_W-1:0]  sliceSum;
  logic              unusedBits;

  assign userOff = busAddr - A_USER_BASE;
  assign cntOff  = busAddr - A_COUNT_BASE;
  assign codeHit = busAddr < ADDR_W'(CODE_WORDS * 4);
  assign userHit = (busAddr >= A_USER_BASE) && (userOff < ADDR_W'(USER_WORDS * 4));
  assign cntHit  = (busAddr >= A_COUNT_BASE) && (cntOff < ADDR_W'(PAGES * 4));
  assign hitIdx  = userHit ? IDX_W'(userOff >> 2) : IDX_W'(busAddr >> 2);
  assign uFull   = uCount >= UC_W'(MAX_UWRITES);
  assign opPage  = strb.idx[PG_IDX-1:0];
  assign rdPage  = PG_IDX'(int'(hitIdx[CW_IDX-1:0]) / PAGE_WORDS);
  assign sliceSum = accum[opPage] + ACC_W'(strb.dur);
  assign unusedBits = ^{strb.idx, userOff[1:0], cntOff[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CODE_WORDS; i++) codeMem[i] <= '1;
      for (int i = 0; i < USER_WORDS; i++) userMem[i] <= '1;
      for (int p = 0; p < PAGES; p++) begin accum[p] <= '0; cycles[p] <= '0; end
      undef  <= '0;
      uCount <= '0;
    end else if (strb.fire) begin
      case (strb.op)
        OP_WRITE: codeMem[strb.idx[CW_IDX-1:0]] <= codeMem[strb.idx[CW_IDX-1:0]] & strb.data;
        OP_UWRITE: begin
          userMem[strb.idx[UW_IDX-1:0]] <= userMem[strb.idx[UW_IDX-1:0]] & strb.data;
          uCount <= uCount + UC_W'(1);
        end
        OP_PAGE: begin
          for (int i = 0; i < CODE_WORDS; i++)
            if (i / PAGE_WORDS == int'(opPage)) codeMem[i] <= '1;
          accum[opPage] <= '0;
          undef[opPage] <= 1'b0;
        end
        OP_ALL: begin
          for (int i = 0; i < CODE_WORDS; i++) codeMem[i] <= '1;
          for (int i = 0; i < USER_WORDS; i++) userMem[i] <= '1;
          for (int p = 0; p < PAGES; p++) accum[p] <= '0;
          undef  <= '0;
          uCount <= '0;
        end
        OP_UERASE: begin
          for (int i = 0; i < USER_WORDS; i++) userMem[i] <= '1;
          uCount <= '0;
        end
        OP_SLICE: begin
          if (sliceSum >= ACC_W'(T_PAGE)) begin
            for (int i = 0; i < CODE_WORDS; i++)
              if (i / PAGE_WORDS == int'(opPage)) codeMem[i] <= '1;
            accum[opPage]  <= '0;
            cycles[opPage] <= cycles[opPage] + CNT_W'(1);
            undef[opPage]  <= 1'b0;
          end else begin
            accum[opPage] <= sliceSum;
            undef[opPage] <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    busErr   = 1'b0;
    if (busValid && !busWe) begin
      if (busAddr == A_READY)          busRdata = DATA_W'(!busy);
      else if (busAddr == A_CONFIG)    busRdata = DATA_W'(cfgMode);
      else if (busAddr == A_SLICE_LEN) busRdata = DATA_W'(sliceLen);
      else if (codeHit) begin
        if (undef[rdPage]) busErr   = 1'b1;
        else               busRdata = codeMem[hitIdx[CW_IDX-1:0]];
      end
      else if (userHit) busRdata = userMem[hitIdx[UW_IDX-1:0]];
      else if (cntHit)  busRdata = DATA_W'(cycles[PG_IDX'(cntOff >> 2)]);
    end
  end

  p_store_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    uCount <= UC_W'(MAX_UWRITES));
  p_all_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.op == OP_ALL) |=> (codeMem[0] == '1 && userMem[0] == '1 && undef == '0));

  for (genvar p = 0; p < PAGES; p++) begin : g_pageChk
    p_total_below_r10: assert property (@(posedge clk) disable iff (!rstN)
      accum[p] < ACC_W'(T_PAGE));
    p_undef_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
      undef[p] |-> (accum[p] != '0));
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rstN)
      (cycles[p] != $past(cycles[p])) |-> (cycles[p] == $past(cycles[p]) + CNT_W'(1)));
  end
endmodule

// File: rtl/flashNvc.sv
module flashNvc
  import flashPkg::*;
#(
  parameter int PAGES       = 4,
  parameter int PAGE_WORDS  = 4,
  parameter int USER_WORDS  = 4,
  parameter int T_WRITE     = 3,
  parameter int T_PAGE      = 20,
  parameter int T_ALL       = 30,
  parameter int MAX_UWRITES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWe,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busErr,
  output logic        stall
);
  strobe_t           strb;
  logic              busy, codeHit, userHit, uFull;
  logic [IDX_W-1:0]  hitIdx;
  logic [1:0]        cfgMode;
  logic [TIME_W-1:0] sliceLen;

  flashCtrl #(.PAGES(PAGES), .T_WRITE(T_WRITE), .T_PAGE(T_PAGE), .T_ALL(T_ALL)) i_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .codeHit(codeHit), .userHit(userHit), .hitIdx(hitIdx),
    .uFull(uFull), .strb(strb), .busy(busy), .cfgMode(cfgMode), .sliceLen(sliceLen));

  flashData #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .USER_WORDS(USER_WORDS),
              .T_PAGE(T_PAGE), .MAX_UWRITES(MAX_UWRITES)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .cfgMode(cfgMode),
    .sliceLen(sliceLen), .busValid(busValid), .busWe(busWe), .busAddr(busAddr),
    .codeHit(codeHit), .userHit(userHit), .hitIdx(hitIdx), .uFull(uFull),
    .busRdata(busRdata), .busErr(busErr));

  assign stall = busy;
endmodule

// File: tb/test_flashNvc.sv
module test_flashNvc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;
  logic        stall;

  always #5 clk = ~clk;

  flashNvc i_flashNvc (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .stall(stall));

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];
  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  // monitor: pops the expected item for each read cycle
  always @(negedge clk) begin
    if (busValid && !busWe) begin
      expItem_t e;
      nCmp++;
      if (sbQ.size() == 0) begin
        nBad++;
        $display("FAIL scoreboard: read with no expectation (actual %h, expected queued item)", busRdata);
      end else begin
        e = sbQ.pop_front();
        if (busRdata !== e.data || busErr !== e.err) begin
          nBad++;
          $display("FAIL %s: actual data=%h err=%b, expected data=%h err=%b",
                   e.tag, busRdata, busErr, e.data, e.err);
        end
      end
    end
  end

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busValid = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busValid = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, input logic [31:0] d, input logic e, input string tag);
    expItem_t it;
    it.data = d; it.err = e; it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk); #2;
    busValid = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic stallLen(input int exp, input string tag);
    int n = 0;
    @(negedge clk);
    while (stall) begin n++; @(negedge clk); end
    nCmp++;
    if (n != exp) begin
      nBad++;
      $display("FAIL %s: actual stall cycles=%0d, expected %0d", tag, n, exp);
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (stall) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    nCmp++;
    if (stall !== 1'b0) begin nBad++; $display("FAIL R1 reset stall: actual %b, expected 0", stall); end
    busRd(12'h400, 32'h1, 1'b0, "R1 ready after reset");
    busRd(12'h000, ONES, 1'b0, "R3 code erased after reset");

    // R3: store ignored in read-only mode
    busWr(12'h004, 32'h0);
    stallLen(0, "R3 store without store mode");
    busRd(12'h004, ONES, 1'b0, "R3 store without store mode");

    // R3 / R1: store mode, timing and AND behaviour
    busWr(12'h504, 32'h1);
    busRd(12'h504, 32'h1, 1'b0, "R3 mode readback");
    busWr(12'h004, 32'h1234_5678);
    stallLen(3, "R1 store stall length");
    busRd(12'h004, 32'h1234_5678, 1'b0, "R3 stored word");
    busWr(12'h004, 32'hFFFF_00FF);
    waitIdle();
    busRd(12'h004, 32'h1234_0078, 1'b0, "R3 AND of old and new");
    busWr(12'h010, 32'h0000_BEEF);
    waitIdle();

    // R4: settings area store limit
    busWr(12'h100, 32'hFFFF_FFF0); waitIdle();
    busWr(12'h104, 32'hFFFF_FF0F); waitIdle();
    busWr(12'h108, 32'h0);
    stallLen(0, "R4 store beyond limit");
    busRd(12'h108, ONES, 1'b0, "R4 store beyond limit");
    busRd(12'h100, 32'hFFFF_FFF0, 1'b0, "R4 store within limit");

    // R5: erase commands need erase mode
    busWr(12'h508, 32'h0);
    stallLen(0, "R5 page erase in store mode");
    busWr(12'h50C, 32'h1);
    stallLen(0, "R5 full erase in store mode");
    busRd(12'h004, 32'h1234_0078, 1'b0, "R5 page kept");

    // R2: command during a running erase is ignored
    busWr(12'h504, 32'h2);
    busWr(12'h508, 32'h3);
    busRd(12'h400, 32'h0, 1'b0, "R1 ready low while busy");
    busWr(12'h50C, 32'h1);
    waitIdle();
    busRd(12'h010, 32'h0000_BEEF, 1'b0, "R2 full erase during busy ignored");
    busRd(12'h100, 32'hFFFF_FFF0, 1'b0, "R2 settings kept");
    busWr(12'h010, 32'h0);
    stallLen(0, "R3 store in erase mode");

    // R6: page erase via second offset, bad index
    busWr(12'h510, 32'h0);
    stallLen(20, "R6 page erase time");
    busRd(12'h004, ONES, 1'b0, "R6 page erased");
    busRd(12'h010, 32'h0000_BEEF, 1'b0, "R6 other page kept");
    busWr(12'h508, 32'h4);
    stallLen(0, "R6 out of range page");

    // R8: settings erase
    busWr(12'h514, 32'h1);
    stallLen(20, "R8 settings erase time");
    busRd(12'h100, ONES, 1'b0, "R8 settings erased");
    busRd(12'h104, ONES, 1'b0, "R8 settings erased");
    busRd(12'h010, 32'h0000_BEEF, 1'b0, "R8 code kept");
    busWr(12'h504, 32'h1);
    busWr(12'h108, 32'h0);
    stallLen(3, "R8 store count reset");
    busRd(12'h108, 32'h0, 1'b0, "R8 store after erase");
    busWr(12'h504, 32'h2);

    // R9 / R10: sliced erase of page 1
    busWr(12'h51C, 32'd8);
    busRd(12'h51C, 32'd8, 1'b0, "R9 slice readback");
    busWr(12'h518, 32'h1);
    stallLen(8, "R9 slice stall length");
    busRd(12'h010, 32'h0, 1'b1, "R9 undefined after one slice");
    busRd(12'h604, 32'h0, 1'b0, "R10 count before completion");
    busWr(12'h518, 32'h1); waitIdle();
    busRd(12'h010, 32'h0, 1'b1, "R9 undefined after two slices");
    busWr(12'h518, 32'h1); waitIdle();
    busRd(12'h010, ONES, 1'b0, "R10 erase complete");
    busRd(12'h604, 32'h1, 1'b0, "R10 count incremented");

    // R6: full erase clears a pending total
    busWr(12'h518, 32'h1); waitIdle();
    busRd(12'h010, 32'h0, 1'b1, "R9 undefined again");
    busWr(12'h508, 32'h1); waitIdle();
    busRd(12'h010, ONES, 1'b0, "R6 full erase clears mark");
    busWr(12'h518, 32'h1); waitIdle();
    busWr(12'h518, 32'h1); waitIdle();
    busRd(12'h010, 32'h0, 1'b1, "R6 total was reset by full erase");
    busWr(12'h518, 32'h1); waitIdle();
    busRd(12'h604, 32'h2, 1'b0, "R10 second completion");
    busRd(12'h600, 32'h0, 1'b0, "R10 other counter untouched");

    // R9: zero slice acts as one cycle
    busWr(12'h51C, 32'h0);
    busWr(12'h518, 32'h2);
    stallLen(1, "R9 zero slice length");
    busRd(12'h020, 32'h0, 1'b1, "R9 page 2 undefined");

    // R11: slice index out of range
    busWr(12'h518, 32'h4);
    stallLen(0, "R11 slice index equal to page count");
    busWr(12'h518, 32'h40);
    stallLen(0, "R11 slice index into settings");
    busRd(12'h108, 32'h0, 1'b0, "R11 settings untouched");

    // R7: full erase
    busWr(12'h504, 32'h1);
    busWr(12'h000, 32'h0); waitIdle();
    busWr(12'h10C, 32'h0); waitIdle();
    busWr(12'h504, 32'h2);
    busWr(12'h50C, 32'h1);
    stallLen(30, "R7 full erase time");
    busRd(12'h000, ONES, 1'b0, "R7 code erased");
    busRd(12'h10C, ONES, 1'b0, "R7 settings erased");
    busRd(12'h020, ONES, 1'b0, "R7 undefined mark cleared");
    busWr(12'h504, 32'h1);
    busWr(12'h100, 32'h0000_000F);
    stallLen(3, "R7 store count reset");
    busRd(12'h100, 32'h0000_000F, 1'b0, "R7 store after full erase");

    repeat (3) @(posedge clk);
    nCmp++;
    if (sbQ.size() != 0) begin
      nBad++;
      $display("FAIL scoreboard: actual %0d items left, expected 0", sbQ.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual run still going, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule